// File: doc/BRIEF.md
# Pipeline Hazard Stall Scoreboard

This block tells a small in-order 32-bit core how many bubble cycles each issued instruction must wait before it executes. It keeps a short history of register-write bitmasks. One pipeline records every register that each recent instruction modified, two instructions deep. A second pipeline records the registers filled by multi-register block loads, three instructions deep. Each incoming instruction descriptor is compared against both histories. The block then sums the stall cycles for every hazard cause that applies. The register file, the decoder and memory are outside the block: the core supplies the register indices, the operation flags, the block-transfer address and the low PC bits.

A history mask has 32 positions. Index r of the general registers (0..15) maps to bit r. Index k of the special registers (0..15) maps to bit 16+k. Two special registers always read as zero, so their positions are reused. Bit 16 records that a jump happened and bit 20 records that a memory write happened. Bit 23 is the multiply-overflow register.

After it accepts a descriptor with S stall cycles, the block holds `in_ready` low for S cycles. Each of those cycles ages both histories by one step and inserts an empty mask. The instruction's own write masks enter the histories after its stalls. Eight saturating counters accumulate the stall cycles of each cause, and `cnt_sel` selects which one appears on `cnt_data`.

Top module: `hazard_stall_sb`

## Requirements
- R1: After synchronous reset `in_ready` is 1, `stall_cnt` is 0, all counters are 0 and both histories are empty, so a lone instruction incurs no stall.
- R2: A source (`src_vld`) or destination-in (`din_vld`) register written by a block load one, two or three instructions back costs 3, 2 or 1 stalls; the source and destination-in costs add. A block load writes registers 0..`blk_last`.
- R3: Every stall cycle shifts an all-zero mask into both histories; the instruction's own masks enter only after its last stall, so history ages during stalls.
- R4: With `mem_op` set, an address register (`src_idx`) written by the previous instruction costs 1 stall.
- R5: With `mem_rd` set, a memory write (`mem_wr`) by either of the two previous instructions costs 2 stalls.
- R6: With `jmp_reg` set, a target register `src_idx` (special register k is index 16+k) written by the previous instruction costs 2 stalls, or 1 stall if written two back.
- R7: When the previous instruction was a jump (`jmp` or `jmp_reg`), `imm16` costs 1 stall when `pc_hw` (PC bits 4:1) is 4'b1111, and `imm32` costs 1 stall when `pc_hw` is 4'b1110.
- R8: With `blk_st` set, registers 0..`blk_last` cost 2 stalls if any was written by the previous instruction, else 1 if any was written two back.
- R9: A block load or store costs 1 stall per 32-byte line boundary inside `blk_addr` .. `blk_addr`+4*(`blk_last`+1)-1.
- R10: With `mul` set, operands `src_idx` or `din_idx` written by the previous instruction cost 1 stall; a multiply marks bit 23 as written.
- R11: A destination-out (`dout_idx`) of 16 or 20 sets no history bit.
- R12: `stall_cnt` shows the stall total of the last accepted instruction from the cycle after acceptance, and `in_ready` is low for exactly that many cycles.
- R13: Counter select codes are 0 block-load dest, 1 memory address, 2 read-after-write, 3 jump register, 4 jump immediate, 5 block-store source, 6 line crossing, 7 multiply. Counters saturate at all ones, and `cnt_clr` clears them at the next edge, taking precedence over adds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Synchronous clear of the cause counters |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Block can accept a descriptor |
| src_vld | input | 1 | Source register is read |
| src_idx | input | 5 | Source / address / jump-target register index |
| din_vld | input | 1 | Destination-in register is read |
| din_idx | input | 5 | Destination-in register index |
| dout_vld | input | 1 | Destination-out register is written |
| dout_idx | input | 5 | Destination-out register index |
| mem_op | input | 1 | Memory operand addressed by src_idx |
| mem_rd | input | 1 | Memory read |
| mem_wr | input | 1 | Memory write |
| jmp | input | 1 | Jump |
| jmp_reg | input | 1 | Jump to register src_idx |
| imm16 | input | 1 | 16-bit immediate fetch |
| imm32 | input | 1 | 32-bit immediate fetch |
| mul | input | 1 | Multiply of src_idx by din_idx |
| blk_ld | input | 1 | Block load of registers 0..blk_last |
| blk_st | input | 1 | Block store of registers 0..blk_last |
| blk_last | input | 4 | Highest register of the block transfer |
| blk_addr | input | 32 | Block transfer start address |
| pc_hw | input | 4 | PC bits 4:1 of the instruction |
| stall_cnt | output | 5 | Stall total of the last accepted instruction |
| cnt_sel | input | 3 | Cause counter select |
| cnt_data | output | CNT_W | Selected cause counter |

## Verification
An instruction accepted at a rising edge shows its stall total on `stall_cnt` and a low `in_ready` right after that edge. Its counter increments also appear after that same edge, and `in_ready` returns after exactly S further edges. The bench drives and samples on the falling edge. A behavioural model advances one step per rising edge, and its ready, stall total and selected counter are compared with the design every cycle. The directed cases are separated by three empty instructions so that each hazard distance is set up on purpose. A narrow counter width makes saturation reachable.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    localparam int REG_BITS   = 32;
    localparam int IDX_W      = 5;
    localparam int MOD_DEPTH  = 2;
    localparam int BLK_DEPTH  = 3;
    localparam int JMP_BIT    = 16;
    localparam int MEMWR_BIT  = 20;
    localparam int MULOV_BIT  = 23;
    localparam int NCAUSE     = 8;
    localparam int AMT_W      = 3;
    localparam int STALL_W    = 5;
    localparam int LINE_SHIFT = 5;
    localparam int SEL_W      = $clog2(NCAUSE);

    typedef logic [REG_BITS-1:0] regmask_t;

    typedef enum logic [SEL_W-1:0] {
        C_BLKDST  = 3'd0,
        C_MEMSRC  = 3'd1,
        C_MEMRAW  = 3'd2,
        C_JMPSRC  = 3'd3,
        C_JMPTGT  = 3'd4,
        C_BLKSRC  = 3'd5,
        C_BLKADDR = 3'd6,
        C_MUL     = 3'd7
    } cause_e;

    typedef struct packed {
        logic             src_vld;
        logic [IDX_W-1:0] src_idx;
        logic             din_vld;
        logic [IDX_W-1:0] din_idx;
        logic             dout_vld;
        logic [IDX_W-1:0] dout_idx;
        logic             mem_op;
        logic             mem_rd;
        logic             mem_wr;
        logic             jmp;
        logic             jmp_reg;
        logic             imm16;
        logic             imm32;
        logic             mul;
        logic             blk_ld;
        logic             blk_st;
        logic [3:0]       blk_last;
        logic [31:0]      blk_addr;
        logic [3:0]       pc_hw;
    } insn_t;

    function automatic regmask_t low_mask(input logic [3:0] last);
        regmask_t m = '0;
        for (int i = 0; i < 16; i++)
            if (i <= int'(last)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [AMT_W-1:0] age_cost(input regmask_t a1, input regmask_t a2,
                                                  input regmask_t a3, input logic [IDX_W-1:0] r);
        if (a1[r])      return 3'd3;
        else if (a2[r]) return 3'd2;
        else if (a3[r]) return 3'd1;
        return 3'd0;
    endfunction
endpackage

// File: rtl/hsb_history.sv
module hsb_history #(
    parameter int W = 32,
    parameter int D = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic [W-1:0]        din,
    output logic [D-1:0][W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < D; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)        q[g] <= '0;
                else if (shift) q[g] <= (g == 0) ? din : q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate
endmodule

// File: rtl/hsb_hazard_eval.sv
module hsb_hazard_eval
    import hsb_pkg::*;
(
    input  insn_t                              d,
    input  logic [MOD_DEPTH-1:0][REG_BITS-1:0] mh,
    input  logic [BLK_DEPTH-1:0][REG_BITS-1:0] bh,
    output logic [NCAUSE-1:0][AMT_W-1:0]       amt,
    output logic [STALL_W-1:0]                 total,
    output regmask_t                           wmask,
    output regmask_t                           bmask
);
    regmask_t   lm;
    logic [1:0] crossed;

    always_comb begin
        lm      = low_mask(d.blk_last);
        crossed = 2'((d.blk_addr + {26'd0, d.blk_last, 2'b00} + 32'd3) >> LINE_SHIFT)
                - 2'(d.blk_addr >> LINE_SHIFT);
        amt = '0;
        amt[C_BLKDST] = (d.src_vld ? age_cost(bh[0], bh[1], bh[2], d.src_idx) : 3'd0)
                      + (d.din_vld ? age_cost(bh[0], bh[1], bh[2], d.din_idx) : 3'd0);
        if (d.mem_op && mh[0][d.src_idx])             amt[C_MEMSRC] = 3'd1;
        if (d.mem_rd && (mh[0][MEMWR_BIT] || mh[1][MEMWR_BIT]))
                                                      amt[C_MEMRAW] = 3'd2;
        if (d.jmp_reg) begin
            if (mh[0][d.src_idx])                     amt[C_JMPSRC] = 3'd2;
            else if (mh[1][d.src_idx])                amt[C_JMPSRC] = 3'd1;
        end
        if (mh[0][JMP_BIT] && ((d.imm16 && d.pc_hw == 4'b1111) ||
                               (d.imm32 && d.pc_hw == 4'b1110)))
                                                      amt[C_JMPTGT] = 3'd1;
        if (d.blk_st) begin
            if ((mh[0] & lm) != '0)                   amt[C_BLKSRC] = 3'd2;
            else if ((mh[1] & lm) != '0)              amt[C_BLKSRC] = 3'd1;
        end
        if (d.blk_st || d.blk_ld)                     amt[C_BLKADDR] = {1'b0, crossed};
        if (d.mul && (mh[0][d.src_idx] || mh[0][d.din_idx]))
                                                      amt[C_MUL] = 3'd1;
    end

    always_comb begin
        total = '0;
        for (int c = 0; c < NCAUSE; c++) total = total + STALL_W'(amt[c]);
    end

    always_comb begin
        wmask = '0;
        if (d.dout_vld && int'(d.dout_idx) != JMP_BIT && int'(d.dout_idx) != MEMWR_BIT)
            wmask[d.dout_idx] = 1'b1;
        if (d.jmp || d.jmp_reg) wmask[JMP_BIT]   = 1'b1;
        if (d.mem_wr)           wmask[MEMWR_BIT] = 1'b1;
        if (d.mul)              wmask[MULOV_BIT] = 1'b1;
        if (d.blk_ld)           wmask = wmask | lm;
        bmask = d.blk_ld ? lm : '0;
    end
endmodule

// File: rtl/hsb_cause_ctr.sv
module hsb_cause_ctr #(
    parameter int N     = 8,
    parameter int CNT_W = 32,
    parameter int AMT_W = 3,
    parameter int SEL_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      add_en,
    input  logic [N-1:0][AMT_W-1:0]   amt,
    input  logic [SEL_W-1:0]          sel,
    output logic [CNT_W-1:0]          rd
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    logic [N-1:0][CNT_W-1:0] cnt_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ctr
            logic [CNT_W:0] sum;
            assign sum = {1'b0, cnt_q[g]} + {{(CNT_W+1-AMT_W){1'b0}}, amt[g]};
            always_ff @(posedge clk) begin
                if (rst || clr)  cnt_q[g] <= '0;
                else if (add_en) cnt_q[g] <= sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
            end

            assert_sat_hold_R13: assert property (@(posedge clk) disable iff (rst)
                (!clr && cnt_q[g] == MAXV) |=> cnt_q[g] == MAXV);
            assert_clear_R13: assert property (@(posedge clk) disable iff (rst)
                clr |=> cnt_q[g] == '0);
        end
    endgenerate

    assign rd = cnt_q[sel];
endmodule

// File: rtl/hazard_stall_sb.sv
module hazard_stall_sb
    import hsb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             src_vld,
    input  logic [4:0]       src_idx,
    input  logic             din_vld,
    input  logic [4:0]       din_idx,
    input  logic             dout_vld,
    input  logic [4:0]       dout_idx,
    input  logic             mem_op,
    input  logic             mem_rd,
    input  logic             mem_wr,
    input  logic             jmp,
    input  logic             jmp_reg,
    input  logic             imm16,
    input  logic             imm32,
    input  logic             mul,
    input  logic             blk_ld,
    input  logic             blk_st,
    input  logic [3:0]       blk_last,
    input  logic [31:0]      blk_addr,
    input  logic [3:0]       pc_hw,
    output logic [4:0]       stall_cnt,
    input  logic [2:0]       cnt_sel,
    output logic [CNT_W-1:0] cnt_data
);
    insn_t                              d;
    logic [MOD_DEPTH-1:0][REG_BITS-1:0] mhist;
    logic [BLK_DEPTH-1:0][REG_BITS-1:0] bhist;
    logic [NCAUSE-1:0][AMT_W-1:0]       amt;
    logic [STALL_W-1:0]                 stall_now, rem_q, stall_q;
    regmask_t                           wmask, bmask, pend_w, pend_b, push_w, push_b;
    logic                               busy_q, accept, shift;

    assign d = '{src_vld: src_vld, src_idx: src_idx, din_vld: din_vld, din_idx: din_idx,
                 dout_vld: dout_vld, dout_idx: dout_idx, mem_op: mem_op, mem_rd: mem_rd,
                 mem_wr: mem_wr, jmp: jmp, jmp_reg: jmp_reg, imm16: imm16, imm32: imm32,
                 mul: mul, blk_ld: blk_ld, blk_st: blk_st, blk_last: blk_last,
                 blk_addr: blk_addr, pc_hw: pc_hw};

    hsb_hazard_eval u_eval (
        .d(d), .mh(mhist), .bh(bhist), .amt(amt), .total(stall_now),
        .wmask(wmask), .bmask(bmask)
    );

    assign in_ready = !busy_q;
    assign accept   = in_valid && !busy_q;
    assign shift    = accept || busy_q;

    always_comb begin
        push_w = '0;
        push_b = '0;
        if (accept && stall_now == '0) begin
            push_w = wmask;
            push_b = bmask;
        end else if (busy_q && rem_q == '0) begin
            push_w = pend_w;
            push_b = pend_b;
        end
    end

    hsb_history #(.W(REG_BITS), .D(MOD_DEPTH)) u_mod_hist (
        .clk(clk), .rst(rst), .shift(shift), .din(push_w), .q(mhist)
    );
    hsb_history #(.W(REG_BITS), .D(BLK_DEPTH)) u_blk_hist (
        .clk(clk), .rst(rst), .shift(shift), .din(push_b), .q(bhist)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rem_q   <= '0;
            stall_q <= '0;
            pend_w  <= '0;
            pend_b  <= '0;
        end else if (accept) begin
            stall_q <= stall_now;
            if (stall_now != '0) begin
                busy_q <= 1'b1;
                rem_q  <= stall_now - 1'b1;
                pend_w <= wmask;
                pend_b <= bmask;
            end
        end else if (busy_q) begin
            if (rem_q == '0) busy_q <= 1'b0;
            else             rem_q  <= rem_q - 1'b1;
        end
    end

    assign stall_cnt = stall_q;

    hsb_cause_ctr #(.N(NCAUSE), .CNT_W(CNT_W), .AMT_W(AMT_W), .SEL_W(SEL_W)) u_ctr (
        .clk(clk), .rst(rst), .clr(cnt_clr), .add_en(accept), .amt(amt),
        .sel(cnt_sel), .rd(cnt_data)
    );

    assert_ready_drop_R12: assert property (@(posedge clk) disable iff (rst)
        (accept && stall_now != '0) |=> !in_ready);
    assert_ready_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (accept && stall_now == '0) |=> in_ready);
    assert_ready_return_R12: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rem_q == '0) |=> in_ready);
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rem_q != '0) |=> (mhist[0] == '0 && bhist[0] == '0));
    assert_no_jmp_mark_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && stall_now == '0 && !jmp && !jmp_reg) |=> !mhist[0][JMP_BIT]);
    assert_no_wr_mark_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && stall_now == '0 && !mem_wr) |=> !mhist[0][MEMWR_BIT]);
    assert_mul_mark_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && stall_now == '0 && mul) |=> mhist[0][MULOV_BIT]);
endmodule

// File: tb/hazard_stall_sb_tb.sv
module hazard_stall_sb_tb;
    import hsb_pkg::*;
    localparam int CW   = 6;
    localparam longint CMAX = (64'd1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_clr = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [4:0] stall_cnt;
    logic [2:0] cnt_sel = '0;
    logic [CW-1:0] cnt_data;
    insn_t cur = '0;

    always #2.5 clk = ~clk;

    hazard_stall_sb #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .in_valid(in_valid), .in_ready(in_ready),
        .src_vld(cur.src_vld), .src_idx(cur.src_idx), .din_vld(cur.din_vld),
        .din_idx(cur.din_idx), .dout_vld(cur.dout_vld), .dout_idx(cur.dout_idx),
        .mem_op(cur.mem_op), .mem_rd(cur.mem_rd), .mem_wr(cur.mem_wr), .jmp(cur.jmp),
        .jmp_reg(cur.jmp_reg), .imm16(cur.imm16), .imm32(cur.imm32), .mul(cur.mul),
        .blk_ld(cur.blk_ld), .blk_st(cur.blk_st), .blk_last(cur.blk_last),
        .blk_addr(cur.blk_addr), .pc_hw(cur.pc_hw), .stall_cnt(stall_cnt),
        .cnt_sel(cnt_sel), .cnt_data(cnt_data)
    );

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] m_mh0, m_mh1, m_mb0, m_mb1, m_mb2, m_pw, m_pb;
    bit m_busy;
    int m_rem, m_last;
    longint m_cnt[8];
    int ma[8];
    logic [31:0] m_wm, m_bm;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit wrote(input logic [31:0] m, input int r);
        return m[r];
    endfunction

    function automatic void model_cost(input insn_t x);
        int n;
        longint lo, hi;
        n = int'(x.blk_last) + 1;
        for (int c = 0; c < 8; c++) ma[c] = 0;
        if (x.src_vld) ma[0] += wrote(m_mb0, x.src_idx) ? 3 : wrote(m_mb1, x.src_idx) ? 2 :
                                wrote(m_mb2, x.src_idx) ? 1 : 0;
        if (x.din_vld) ma[0] += wrote(m_mb0, x.din_idx) ? 3 : wrote(m_mb1, x.din_idx) ? 2 :
                                wrote(m_mb2, x.din_idx) ? 1 : 0;
        if (x.mem_op && wrote(m_mh0, x.src_idx)) ma[1] = 1;
        if (x.mem_rd && (m_mh0[20] || m_mh1[20])) ma[2] = 2;
        if (x.jmp_reg) ma[3] = wrote(m_mh0, x.src_idx) ? 2 : wrote(m_mh1, x.src_idx) ? 1 : 0;
        if (m_mh0[16] && ((x.imm16 && x.pc_hw == 15) || (x.imm32 && x.pc_hw == 14))) ma[4] = 1;
        if (x.blk_st) begin
            bit a = 0, b = 0;
            for (int r = 0; r < n; r++) begin
                a |= m_mh0[r];
                b |= m_mh1[r];
            end
            ma[5] = a ? 2 : b ? 1 : 0;
        end
        if (x.blk_st || x.blk_ld) begin
            lo = longint'(x.blk_addr);
            hi = lo + 4 * n - 1;
            ma[6] = int'(hi / 32 - lo / 32);
        end
        if (x.mul && (wrote(m_mh0, x.src_idx) || wrote(m_mh0, x.din_idx))) ma[7] = 1;
        m_wm = '0;
        m_bm = '0;
        if (x.dout_vld && x.dout_idx != 16 && x.dout_idx != 20) m_wm[x.dout_idx] = 1'b1;
        if (x.jmp || x.jmp_reg) m_wm[16] = 1'b1;
        if (x.mem_wr) m_wm[20] = 1'b1;
        if (x.mul) m_wm[23] = 1'b1;
        if (x.blk_ld) for (int r = 0; r < n; r++) begin
            m_wm[r] = 1'b1;
            m_bm[r] = 1'b1;
        end
    endfunction

    task automatic tick();
        logic [31:0] nh0, nh1, nb0, nb1, nb2, npw, npb;
        bit nbusy;
        int nrem, nlast, s;
        longint ncnt[8];
        cnt_sel = 3'(cyc % 8);
        #1;
        chk(in_ready == !m_busy, "R12", "in_ready", in_ready, !m_busy);
        chk(stall_cnt == 5'(m_last), "R12", "stall_cnt", stall_cnt, m_last);
        chk(cnt_data == CW'(m_cnt[cnt_sel]), "R13", "cnt_data", cnt_data, m_cnt[cnt_sel]);
        nh0 = m_mh0; nh1 = m_mh1; nb0 = m_mb0; nb1 = m_mb1; nb2 = m_mb2;
        npw = m_pw; npb = m_pb; nbusy = m_busy; nrem = m_rem; nlast = m_last;
        for (int c = 0; c < 8; c++) ncnt[c] = cnt_clr ? 0 : m_cnt[c];
        if (in_valid && !m_busy) begin
            model_cost(cur);
            s = 0;
            for (int c = 0; c < 8; c++) begin
                s += ma[c];
                if (!cnt_clr) ncnt[c] = (m_cnt[c] + ma[c] > CMAX) ? CMAX : m_cnt[c] + ma[c];
            end
            nlast = s;
            nh1 = m_mh0; nb2 = m_mb1; nb1 = m_mb0;
            if (s == 0) begin
                nh0 = m_wm; nb0 = m_bm;
            end else begin
                nh0 = '0; nb0 = '0; nbusy = 1; nrem = s - 1; npw = m_wm; npb = m_bm;
            end
        end else if (m_busy) begin
            nh1 = m_mh0; nb2 = m_mb1; nb1 = m_mb0;
            if (m_rem == 0) begin
                nh0 = m_pw; nb0 = m_pb; nbusy = 0;
            end else begin
                nh0 = '0; nb0 = '0; nrem = m_rem - 1;
            end
        end
        @(posedge clk);
        m_mh0 = nh0; m_mh1 = nh1; m_mb0 = nb0; m_mb1 = nb1; m_mb2 = nb2;
        m_pw = npw; m_pb = npb; m_busy = nbusy; m_rem = nrem; m_last = nlast;
        for (int c = 0; c < 8; c++) m_cnt[c] = ncnt[c];
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(input insn_t x, input int exp, input string req);
        int s, low;
        while (!in_ready) tick();
        cur = x;
        in_valid = 1'b1;
        tick();
        in_valid = 1'b0;
        cur = '0;
        s = int'(stall_cnt);
        chk(s == exp, req, "stall total", s, exp);
        low = 0;
        while (!in_ready) begin
            low++;
            tick();
        end
        chk(low == s, "R12", "ready-low cycles", low, s);
    endtask

    task automatic flush();
        insn_t z = '0;
        for (int i = 0; i < 3; i++) run(z, 0, "R3");
    endtask

    task automatic peek(input int sel, input longint exp, input string req);
        cnt_sel = 3'(sel);
        #1;
        chk(cnt_data == CW'(exp), req, "counter", cnt_data, exp);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        insn_t x, z;
        z = '0;
        m_mh0 = '0; m_mh1 = '0; m_mb0 = '0; m_mb1 = '0; m_mb2 = '0;
        m_pw = '0; m_pb = '0; m_busy = 0; m_rem = 0; m_last = 0;
        for (int c = 0; c < 8; c++) m_cnt[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(stall_cnt == 0, "R1", "stall_cnt after reset", stall_cnt, 0);
        for (int c = 0; c < 8; c++) peek(c, 0, "R1");
        x = z; x.src_vld = 1; x.src_idx = 0; x.mem_op = 1; x.mem_rd = 1; x.jmp_reg = 1;
        run(x, 0, "R1");
        flush();

        // R2: block load distance 1, 2, 3 and summed operands
        x = z; x.blk_ld = 1; x.blk_last = 3; run(x, 0, "R2");
        x = z; x.src_vld = 1; x.src_idx = 2; run(x, 3, "R2");
        flush();
        x = z; x.blk_ld = 1; x.blk_last = 3; run(x, 0, "R2");
        run(z, 0, "R2");
        x = z; x.src_vld = 1; x.src_idx = 1; run(x, 2, "R2");
        flush();
        x = z; x.blk_ld = 1; x.blk_last = 3; run(x, 0, "R2");
        run(z, 0, "R2"); run(z, 0, "R2");
        x = z; x.din_vld = 1; x.din_idx = 0; run(x, 1, "R2");
        flush();
        x = z; x.blk_ld = 1; x.blk_last = 3; run(x, 0, "R2");
        x = z; x.src_vld = 1; x.src_idx = 1; x.din_vld = 1; x.din_idx = 2; run(x, 6, "R2");
        x = z; x.src_vld = 1; x.src_idx = 9; run(x, 0, "R2");
        flush();

        // R3: stalls age the history
        x = z; x.blk_ld = 1; x.blk_last = 3; run(x, 0, "R3");
        x = z; x.src_vld = 1; x.src_idx = 1; run(x, 3, "R3");
        x = z; x.din_vld = 1; x.din_idx = 1; run(x, 0, "R3");
        flush();

        // R4: memory address register
        x = z; x.dout_vld = 1; x.dout_idx = 5; run(x, 0, "R4");
        x = z; x.mem_op = 1; x.src_idx = 5; run(x, 1, "R4");
        flush();

        // R5: read after write
        x = z; x.mem_wr = 1; run(x, 0, "R5");
        run(z, 0, "R5");
        x = z; x.mem_rd = 1; run(x, 2, "R5");
        flush();
        x = z; x.mem_wr = 1; run(x, 0, "R5");
        run(z, 0, "R5"); run(z, 0, "R5");
        x = z; x.mem_rd = 1; run(x, 0, "R5");
        flush();

        // R6: jump to register, general and special
        x = z; x.dout_vld = 1; x.dout_idx = 7; run(x, 0, "R6");
        x = z; x.jmp_reg = 1; x.src_idx = 7; run(x, 2, "R6");
        flush();
        x = z; x.dout_vld = 1; x.dout_idx = 7; run(x, 0, "R6");
        run(z, 0, "R6");
        x = z; x.jmp_reg = 1; x.src_idx = 7; run(x, 1, "R6");
        flush();
        x = z; x.dout_vld = 1; x.dout_idx = 19; run(x, 0, "R6");
        x = z; x.jmp_reg = 1; x.src_idx = 19; run(x, 2, "R6");
        flush();

        // R7: immediate after a jump
        x = z; x.jmp = 1; run(x, 0, "R7");
        x = z; x.imm16 = 1; x.pc_hw = 4'hF; run(x, 1, "R7");
        flush();
        x = z; x.jmp = 1; run(x, 0, "R7");
        x = z; x.imm16 = 1; x.pc_hw = 4'hE; run(x, 0, "R7");
        flush();
        x = z; x.jmp = 1; run(x, 0, "R7");
        x = z; x.imm32 = 1; x.pc_hw = 4'hE; run(x, 1, "R7");
        flush();

        // R8: block store source
        x = z; x.dout_vld = 1; x.dout_idx = 2; run(x, 0, "R8");
        x = z; x.blk_st = 1; x.blk_last = 3; run(x, 2, "R8");
        flush();
        x = z; x.dout_vld = 1; x.dout_idx = 1; run(x, 0, "R8");
        run(z, 0, "R8");
        x = z; x.blk_st = 1; x.blk_last = 1; run(x, 1, "R8");
        flush();
        x = z; x.dout_vld = 1; x.dout_idx = 9; run(x, 0, "R8");
        x = z; x.blk_st = 1; x.blk_last = 3; run(x, 0, "R8");
        flush();

        // R9: line crossings
        x = z; x.blk_st = 1; x.blk_last = 3; x.blk_addr = 32'h18; run(x, 1, "R9");
        flush();
        x = z; x.blk_ld = 1; x.blk_last = 15; x.blk_addr = 32'h1C; run(x, 2, "R9");
        flush();
        x = z; x.blk_st = 1; x.blk_last = 7; x.blk_addr = 32'h40; run(x, 0, "R9");
        flush();

        // R10: multiply operand and overflow mark
        x = z; x.dout_vld = 1; x.dout_idx = 4; run(x, 0, "R10");
        x = z; x.mul = 1; x.src_idx = 4; x.din_idx = 6; run(x, 1, "R10");
        flush();
        x = z; x.mul = 1; x.src_idx = 3; x.din_idx = 6; run(x, 0, "R10");
        x = z; x.jmp_reg = 1; x.src_idx = 23; run(x, 2, "R10");
        flush();

        // R11: zero-register writes leave no marker
        x = z; x.dout_vld = 1; x.dout_idx = 16; run(x, 0, "R11");
        x = z; x.imm16 = 1; x.pc_hw = 4'hF; run(x, 0, "R11");
        flush();
        x = z; x.dout_vld = 1; x.dout_idx = 20; run(x, 0, "R11");
        x = z; x.mem_rd = 1; run(x, 0, "R11");
        flush();

        // R13: saturation, then clear
        for (int i = 0; i < 22; i++) begin
            x = z; x.blk_ld = 1; x.blk_last = 0; run(x, 0, "R13");
            x = z; x.src_vld = 1; x.src_idx = 0; run(x, 3, "R13");
        end
        peek(0, CMAX, "R13");
        cnt_clr = 1'b1;
        tick();
        cnt_clr = 1'b0;
        for (int c = 0; c < 8; c++) peek(c, 0, "R13");
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule